// File: doc/BRIEF.md
# GPIO Bank Register File with Guarded Pin Locking

This block holds the register state for one or more banks of 32 general-purpose pins behind a simple memory-mapped bus with address, write data, write strobe and combinational read data. For each bank it keeps an output word, which is changed only through separate set and clear words. It also keeps a synchronized copy of the pin inputs and a per-bank lock mask. Each pin has its own one-bit direction register.

A lock mask protects pins from accidental reconfiguration. A pin whose lock bit is 1 ignores set, clear and direction writes. The lock mask can only be rewritten by a two-write sequence. Software first writes a fixed key word to a key register, and the very next bus write must then go to the bank's lock register. Any other write in between cancels the key. After reset, every pin is an input, every output bit is 0 and every bank is fully locked.

Top module: `gpio_lock_regs`

## Requirements
- R1: While and directly after reset, every output bit is 0, every pin is an input (direction bit 1) and every lock mask is all ones.
- R2: A write to the set word at 0x040 + 4*bank drives high each output bit whose write bit is 1 and whose lock bit is 0. Output bits written 0 keep their value.
- R3: A write to the clear word at 0x060 + 4*bank drives low each output bit whose write bit is 1 and whose lock bit is 0. Output bits written 0 keep their value.
- R4: A read at 0x000 + 4*bank returns that bank's output word, in which bit i is pin 32*bank + i.
- R5: A read at 0x020 + 4*bank returns the bank's pin inputs through a two-flop synchronizer. A change on the pins appears in the read data after the second rising clock edge, not after the first.
- R6: Each pin p has a direction register at 0x100 + 4*p, where bit 0 = 1 means input and 0 means output. A read there returns the bit in position 0 with zeros above it, and the bit is also driven on the direction port.
- R7: A write of 0x00A5A501 to the key register at 0x520 arms the lock. When the next bus write goes to the lock register at 0x500 + 4*bank, it loads that bank's lock mask.
- R8: A write to a lock register that does not directly follow a correct key write is ignored. A key write with any other value, or any other intervening write, disarms the lock.
- R9: Set, clear and direction writes leave unchanged every pin whose lock bit is 1.
- R10: A read at 0x500 + 4*bank returns the bank's lock mask, in which a 1 bit locks the pin.
- R11: Writes to unaligned addresses, to unmapped addresses, or to banks or pins at or beyond the configured count change no state. Reads at those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NUM_BANKS*32 | Asynchronous pin levels |
| pin_out | output | NUM_BANKS*32 | Output level per pin |
| pin_dir_in | output | NUM_BANKS*32 | Direction per pin, 1 = input |

## Verification
The bench builds the block with the default of two banks, which gives 64 pins. At that size it can sweep every direction register and both banks' set, clear and lock words, and check the whole state after each phase. With two banks the bank index 2 becomes a real out-of-range case, and the first control address past pin 63 can be probed as well. It also covers an unlocked and a locked bank side by side, and a bank with a split lock mask, so that the masking of set, clear and direction writes is seen per bit.

// File: rtl/gpio_lk_pkg.sv
package gpio_lk_pkg;

    localparam int ADDR_W       = 12;
    localparam int BANK_PINS    = 32;
    localparam int MAX_BANKS    = 8;
    localparam int BANK_IDX_W   = $clog2(MAX_BANKS);
    localparam int PIN_IDX_W    = $clog2(MAX_BANKS * BANK_PINS);

    localparam logic [ADDR_W-1:0] CTL_BASE  = 12'h100;
    localparam logic [ADDR_W-1:0] LOCK_BASE = 12'h500;
    localparam logic [ADDR_W-1:0] KEY_ADDR  = 12'h520;
    localparam logic [31:0]       UNLOCK_KEY = 32'h00A5_A501;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_OUT,
        RG_IN,
        RG_SET,
        RG_CLR,
        RG_CTL,
        RG_LOCK,
        RG_KEY
    } reg_region_e;

    typedef struct packed {
        reg_region_e            region;
        logic [BANK_IDX_W-1:0]  bank;
        logic [PIN_IDX_W-1:0]   pin;
    } bus_decode_t;

    function automatic bus_decode_t decode_addr(input logic [ADDR_W-1:0] a,
                                                input int nbanks);
        bus_decode_t       d;
        logic [ADDR_W-1:0] rel;
        d.region = RG_NONE;
        d.bank   = a[4:2];
        d.pin    = '0;
        rel      = a - CTL_BASE;
        if (a[1:0] == 2'b00) begin
            if (a[ADDR_W-1:7] == '0) begin
                if (int'(a[4:2]) < nbanks) begin
                    case (a[6:5])
                        2'd0:    d.region = RG_OUT;
                        2'd1:    d.region = RG_IN;
                        2'd2:    d.region = RG_SET;
                        default: d.region = RG_CLR;
                    endcase
                end
            end else if (a >= CTL_BASE &&
                         int'(a) < int'(CTL_BASE) + 4 * nbanks * BANK_PINS) begin
                d.region = RG_CTL;
                d.pin    = rel[PIN_IDX_W+1:2];
            end else if (a[ADDR_W-1:5] == LOCK_BASE[ADDR_W-1:5]) begin
                if (int'(a[4:2]) < nbanks) d.region = RG_LOCK;
            end else if (a == KEY_ADDR) begin
                d.region = RG_KEY;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_lk_decode.sv
module gpio_lk_decode
    import gpio_lk_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output bus_decode_t       dec
);
    always_comb dec = decode_addr(addr, NUM_BANKS);
endmodule

// File: rtl/gpio_lk_sync.sv
module gpio_lk_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_lk_bank.sv
module gpio_lk_bank
    import gpio_lk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_we,
    input  logic                 clr_we,
    input  logic                 lock_we,
    input  logic [BANK_PINS-1:0] ctl_we,
    input  logic [31:0]          wdata,
    output logic [BANK_PINS-1:0] out_q,
    output logic [BANK_PINS-1:0] dir_q,
    output logic [BANK_PINS-1:0] lock_q
);
    logic [BANK_PINS-1:0] free_bits;

    assign free_bits = wdata[BANK_PINS-1:0] & ~lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            lock_q <= '1;
        end else begin
            if (lock_we) lock_q <= wdata[BANK_PINS-1:0];
            if (set_we)      out_q <= out_q | free_bits;
            else if (clr_we) out_q <= out_q & ~free_bits;
        end
    end

    for (genvar i = 0; i < BANK_PINS; i++) begin : g_dir
        always_ff @(posedge clk) begin
            if (rst)                          dir_q[i] <= 1'b1;
            else if (ctl_we[i] && !lock_q[i]) dir_q[i] <= wdata[0];
        end
    end
endmodule

// File: rtl/gpio_lock_regs.sv
module gpio_lock_regs
    import gpio_lk_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [11:0]                   bus_addr,
    input  logic [31:0]                   bus_wdata,
    input  logic                          bus_we,
    output logic [31:0]                   bus_rdata,
    input  logic [NUM_BANKS*32-1:0]       pin_in,
    output logic [NUM_BANKS*32-1:0]       pin_out,
    output logic [NUM_BANKS*32-1:0]       pin_dir_in
);
    localparam int NPINS = NUM_BANKS * BANK_PINS;

    bus_decode_t      dec;
    logic             armed;
    logic [NPINS-1:0] out_all;
    logic [NPINS-1:0] dir_all;
    logic [NPINS-1:0] lock_all;
    logic [NPINS-1:0] in_sync;

    gpio_lk_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    gpio_lk_sync #(.WIDTH(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (in_sync)
    );

    // Key arming: only the write immediately after a correct key write counts.
    always_ff @(posedge clk) begin
        if (rst)         armed <= 1'b0;
        else if (bus_we) armed <= (dec.region == RG_KEY) && (bus_wdata == UNLOCK_KEY);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic                 hit;
        logic [BANK_PINS-1:0] ctl_we;

        assign hit = bus_we && (dec.bank == BANK_IDX_W'(b));

        for (genvar i = 0; i < BANK_PINS; i++) begin : g_ctl
            assign ctl_we[i] = bus_we && (dec.region == RG_CTL) &&
                               (dec.pin == PIN_IDX_W'(b * BANK_PINS + i));
        end

        gpio_lk_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .set_we  (hit && dec.region == RG_SET),
            .clr_we  (hit && dec.region == RG_CLR),
            .lock_we (hit && dec.region == RG_LOCK && armed),
            .ctl_we  (ctl_we),
            .wdata   (bus_wdata),
            .out_q   (out_all[b*BANK_PINS +: BANK_PINS]),
            .dir_q   (dir_all[b*BANK_PINS +: BANK_PINS]),
            .lock_q  (lock_all[b*BANK_PINS +: BANK_PINS])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec.bank == BANK_IDX_W'(b)) begin
                case (dec.region)
                    RG_OUT:  bus_rdata = out_all[b*BANK_PINS +: BANK_PINS];
                    RG_IN:   bus_rdata = in_sync[b*BANK_PINS +: BANK_PINS];
                    RG_LOCK: bus_rdata = lock_all[b*BANK_PINS +: BANK_PINS];
                    default: ;
                endcase
            end
        end
        if (dec.region == RG_CTL) begin
            for (int p = 0; p < NPINS; p++) begin
                if (dec.pin == PIN_IDX_W'(p)) bus_rdata = {31'b0, dir_all[p]};
            end
        end
    end

    assign pin_out    = out_all;
    assign pin_dir_in = dir_all;
endmodule

// File: rtl/gpio_lock_regs_chk.sv
module gpio_lock_regs_chk
    import gpio_lk_pkg::*;
#(
    parameter int NPINS = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_we,
    input logic [11:0]      bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_dir_in,
    input logic [NPINS-1:0] lock_all,
    input logic             armed
);
    assert_reset_state_R1: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (pin_out == '0 && (&pin_dir_in) && (&lock_all)));

    assert_arm_needs_key_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> ($past(bus_we) && $past(bus_addr) == KEY_ADDR &&
                          $past(bus_wdata) == UNLOCK_KEY));

    assert_other_write_disarms_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !(bus_addr == KEY_ADDR && bus_wdata == UNLOCK_KEY)) |=> !armed);

    assert_lock_guarded_R8: assert property (@(posedge clk) disable iff (rst)
        (lock_all != $past(lock_all)) |-> ($past(armed) && $past(bus_we)));

    assert_locked_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pin_out ^ $past(pin_out)) & $past(lock_all)) == '0));

    assert_locked_dir_hold_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pin_dir_in ^ $past(pin_dir_in)) & $past(lock_all)) == '0));
endmodule

bind gpio_lock_regs gpio_lock_regs_chk #(.NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pin_out    (pin_out),
    .pin_dir_in (pin_dir_in),
    .lock_all   (lock_all),
    .armed      (armed)
);

// File: tb/tb_gpio_lock_regs.sv
module tb_gpio_lock_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;
    localparam int NP = NB * 32;
    localparam logic [31:0] KEY = 32'h00A5_A501;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_dir_in;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0]   m_out  [NB];
    logic [31:0]   m_lock [NB];
    logic [NP-1:0] m_dir;
    bit            m_armed;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_lock_regs #(.NUM_BANKS(NB)) dut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_rdata  (bus_rdata),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_dir_in (pin_dir_in)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bus write plus the requirement-level model of its effect.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bit nxt_armed;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        nxt_armed = (a == 12'h520) && (d == KEY);
        for (int b = 0; b < NB; b++) begin
            if (a == 12'(12'h040 + 4*b)) m_out[b] = m_out[b] | (d & ~m_lock[b]);
            if (a == 12'(12'h060 + 4*b)) m_out[b] = m_out[b] & ~(d & ~m_lock[b]);
            if (a == 12'(12'h500 + 4*b) && m_armed) m_lock[b] = d;
        end
        for (int p = 0; p < NP; p++) begin
            if (a == 12'(12'h100 + 4*p) && !m_lock[p/32][p%32]) m_dir[p] = d[0];
        end
        m_armed = nxt_armed;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_we = 1'b0;
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic verify_all(input string tag);
        logic [31:0] v;
        for (int b = 0; b < NB; b++) begin
            rd(12'(4*b), v);           chk({tag, " R4 out word"}, 64'(v), 64'(m_out[b]));
            rd(12'(12'h500 + 4*b), v); chk({tag, " R10 lock word"}, 64'(v), 64'(m_lock[b]));
        end
        for (int p = 0; p < NP; p++) begin
            rd(12'(12'h100 + 4*p), v);
            chk({tag, " R6 dir reg"}, 64'(v), {63'b0, m_dir[p]});
        end
        chk({tag, " R2 R3 pin_out port"}, 64'(pin_out), {m_out[1], m_out[0]});
        chk({tag, " R6 R9 pin_dir_in port"}, 64'(pin_dir_in), 64'(m_dir));
    endtask

    initial begin
        logic [31:0] v;
        for (int b = 0; b < NB; b++) begin m_out[b] = '0; m_lock[b] = '1; end
        m_dir = '1;
        m_armed = 0;
        repeat (3) @(negedge clk);
        chk("R1 pin_out during reset", 64'(pin_out), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        verify_all("R1 after reset");

        // Locked bank rejects set and direction writes.
        wr(12'h040, 32'hFFFF_FFFF);
        wr(12'h104, 32'h0);
        verify_all("R9 fully locked");

        // Lock writes without a valid key go nowhere.
        wr(12'h500, 32'h0);
        wr(12'h520, KEY); wr(12'h044, 32'h1); wr(12'h500, 32'h0);
        wr(12'h520, 32'h00A5_A500); wr(12'h504, 32'h0);
        wr(12'h520, KEY); wr(12'h042, 32'h0); wr(12'h504, 32'h0);
        verify_all("R8 unguarded lock write");

        // Proper sequence: split mask on bank 0, full unlock on bank 1.
        wr(12'h520, KEY); wr(12'h500, 32'h0000_FFFF);
        wr(12'h520, KEY); wr(12'h504, 32'h0);
        verify_all("R7 lock load");

        wr(12'h040, 32'hFFFF_FFFF);
        verify_all("R2 R9 set through split mask");
        chk("R9 bank0 locked half low", 64'(pin_out[31:0]), 64'hFFFF_0000);
        wr(12'h044, 32'hA5A5_0F0F);
        wr(12'h044, 32'h0);
        verify_all("R2 set pattern");
        chk("R2 bank1 set pattern", 64'(pin_out[63:32]), 64'hA5A5_0F0F);
        wr(12'h064, 32'h0000_FFFF);
        wr(12'h060, 32'h00FF_00FF);
        verify_all("R3 clear pattern");
        chk("R3 bank1 after clear", 64'(pin_out[63:32]), 64'hA5A5_0000);
        chk("R3 bank0 after clear", 64'(pin_out[31:0]), 64'hFF00_0000);

        // Direction sweep over every pin, then alternate back.
        for (int p = 0; p < NP; p++) wr(12'(12'h100 + 4*p), 32'hFFFF_FFFE);
        verify_all("R6 R9 all to output");
        for (int p = 0; p < NP; p++) wr(12'(12'h100 + 4*p), 32'(p % 2));
        verify_all("R6 alternate directions");

        // Input synchronizer latency.
        for (int k = 0; k < 4; k++) begin
            logic [NP-1:0] prev;
            logic [NP-1:0] pat;
            prev = pin_in;
            pat = {32'hC3C3_0000 ^ 32'(k * 32'h1111_1111), 32'h5A5A_F00F + 32'(k)};
            rd(12'h020, v);
            pin_in = pat;
            @(posedge clk); #1;
            chk("R5 one edge still old", 64'(bus_rdata), 64'(prev[31:0]));
            @(posedge clk); #1;
            chk("R5 two edges new", 64'(bus_rdata), 64'(pat[31:0]));
            rd(12'h024, v);
            chk("R5 bank1 input", 64'(v), 64'(pat[63:32]));
            @(negedge clk);
        end

        // Out-of-range and unaligned accesses.
        rd(12'h008, v); chk("R11 bank2 out read", 64'(v), 64'h0);
        rd(12'h508, v); chk("R11 bank2 lock read", 64'(v), 64'h0);
        rd(12'h200, v); chk("R11 pin64 dir read", 64'(v), 64'h0);
        rd(12'h520, v); chk("R11 key read", 64'(v), 64'h0);
        rd(12'h041, v); chk("R11 unaligned read", 64'(v), 64'h0);
        wr(12'h048, 32'hFFFF_FFFF);
        wr(12'h045, 32'hFFFF_FFFF);
        wr(12'h066, 32'hFFFF_FFFF);
        wr(12'h200, 32'h0);
        wr(12'h520, KEY); wr(12'h508, 32'h0);
        verify_all("R11 ignored writes");

        // Relock bank 1 and try to change it.
        wr(12'h520, KEY); wr(12'h504, 32'hFFFF_FFFF);
        wr(12'h064, 32'hFFFF_FFFF);
        wr(12'h180, 32'h1);
        verify_all("R9 relocked bank");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule